// File: doc/BRIEF.md
# Four-Port Write-Triggered Command Register Bank

This block is the command side of a register bank for a four-port power controller. Software writes to three write-only command addresses on a simple register bus. Each 1 in the written byte fires one action: it starts a detection or classification cycle, sets or clears a port's power enable, resets one port, or returns the whole bank to its power-on state. A 0 bit does nothing, so one port can be driven without a read-modify-write of the others. Reads of the command addresses always return zero.

The bank holds the per-port state that these commands change: power enable, detection and classification enables, the detect and fault event flags, and a small status field. It also holds two global flags: the latched auto-mode strap and a supply undervoltage flag. Each port's operating mode and the state of its overcurrent cooldown timer come in as plain inputs. Event flags and status are loaded from outside through dedicated inputs.

Each write is registered into one-cycle action pulses on the clock edge that samples the strobe. The per-port state takes the result on the following edge.

Top module: `pb_cmd_bank`

## Requirements
- R1: A read of any address returns 0x00 on `bus_rdata` one cycle after `bus_rd`, and no read changes any state.
- R2: A 0 bit in a command write has no effect. A write to an address other than 0x18, 0x19 or 0x1A changes nothing.
- R3: Mode per port i is `port_mode[2i+1:2i]`: 00 shutdown, 01 manual, 10 semi-auto, 11 auto. At 0x18 in manual mode, bit i pulses `det_start[i]` and bit 4+i pulses `cls_start[i]`.
- R4: At 0x18 in semi-auto or auto mode, bit i sets `det_en[i]` and bit 4+i sets `cls_en[i]`, with no start pulse. In shutdown mode the write does nothing.
- R5: At 0x19, bit i sets `pwr_en[i]` unless the port is in shutdown or `cool_busy[i]` is high.
- R6: At 0x19, bit 4+i in any mode except shutdown clears `pwr_en`, `det_en`, `cls_en`, `det_evt`, `flt_evt` and the status of port i. When the set and clear bits for a port arrive in the same write, the clear wins.
- R7: At 0x1A, bit i clears the same set of port state as R6 in every mode, shutdown included.
- R8: At 0x1A, bit 4 clears all port state, reloads `auto_mode` from `auto_strap` and leaves `uvlo_flag` at 0. After `rst_n`, `uvlo_flag` is 1 and `auto_mode` follows the strap. Bit 5 has no effect.
- R9: Start pulses last exactly one cycle, in the cycle after the write strobe. State changes appear one cycle after that.
- R10: `det_evt_set`, `flt_evt_set` and `stat_wr` set the event flags and load the status on the next edge. `uvlo_set` sets `uvlo_flag`. A clearing command that lands on the same edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered |
| port_mode | input | 8 | Two-bit mode per port |
| cool_busy | input | 4 | Overcurrent cooldown timer nonzero, per port |
| auto_strap | input | 1 | Auto-mode strap level |
| det_evt_set | input | 4 | Sets detect event flag per port |
| flt_evt_set | input | 4 | Sets fault event flag per port |
| stat_wr | input | 4 | Loads port status per port |
| stat_in | input | 12 | Status value, 3 bits per port |
| uvlo_set | input | 1 | Sets the undervoltage flag |
| det_start | output | 4 | One-cycle detection start pulse |
| cls_start | output | 4 | One-cycle classification start pulse |
| pwr_en | output | 4 | Power enable per port |
| det_en | output | 4 | Detection enable per port |
| cls_en | output | 4 | Classification enable per port |
| det_evt | output | 4 | Detect event flag per port |
| flt_evt | output | 4 | Fault event flag per port |
| port_status | output | 12 | Status, 3 bits per port |
| auto_mode | output | 1 | Latched strap value |
| uvlo_flag | output | 1 | Undervoltage flag |

## Verification
A wrong decode or mode gate shows up in two places. It appears as a start pulse or an enable bit on the wrong port, one cycle after the strobe for pulses and two cycles after for state. A broken clear cascade leaves one of the six per-port fields standing after a power clear or a port reset. A missed refusal lets `pwr_en` rise while the cooldown input is high. Every command is followed by a full compare of all port outputs, so an error in one field cannot hide behind a correct value in another.

// File: rtl/pb_cmd_pkg.sv
// Package: shared types for the command register bank.
// Assumes two mode bits per port and one command bundle per port.
package pb_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_MANUAL = 2'b01,
        MODE_SEMI   = 2'b10,
        MODE_AUTO   = 2'b11
    } port_mode_e;

    // Registered per-port actions decoded from one bus write
    typedef struct packed {
        logic det_go;
        logic cls_go;
        logic pwr_set;
        logic pwr_clr;
        logic port_rst;
    } port_cmd_t;

endpackage

// File: rtl/pb_cmd_decode.sv
// Module: pb_cmd_decode
// Turns one bus write into registered one-cycle action pulses per port,
// plus a global reset pulse. It assumes that per-port fields sit in bits
// [NP-1:0] and [2*NP-1:NP] of the write data, and that the global reset
// bit lies above the per-port reset bits.
module pb_cmd_decode
    import pb_cmd_pkg::*;
#(
    parameter int NP       = 4,
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int GLOB_BIT = 4,
    parameter logic [AW-1:0] ADDR_RESTART = 8'h18,
    parameter logic [AW-1:0] ADDR_POWER   = 8'h19,
    parameter logic [AW-1:0] ADDR_RESET   = 8'h1A
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 bus_wr,
    output port_cmd_t [NP-1:0]   cmd_q,
    output logic                 glob_q
);

    logic hit_restart, hit_power, hit_reset;
    port_cmd_t [NP-1:0] cmd_d;

    // Address match, qualified by the write strobe
    always_comb begin
        hit_restart = bus_wr && (bus_addr == ADDR_RESTART);
        hit_power   = bus_wr && (bus_addr == ADDR_POWER);
        hit_reset   = bus_wr && (bus_addr == ADDR_RESET);
    end

    // Per-port bit extraction: only 1 bits produce an action
    for (genvar i = 0; i < NP; i++) begin : g_bits
        always_comb begin
            cmd_d[i].det_go   = hit_restart && bus_wdata[i];
            cmd_d[i].cls_go   = hit_restart && bus_wdata[NP+i];
            cmd_d[i].pwr_set  = hit_power   && bus_wdata[i];
            cmd_d[i].pwr_clr  = hit_power   && bus_wdata[NP+i];
            cmd_d[i].port_rst = hit_reset   && bus_wdata[i];
        end
    end

    // Register the action pulses so that each lasts one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            glob_q <= 1'b0;
        end else begin
            cmd_q  <= cmd_d;
            glob_q <= hit_reset && bus_wdata[GLOB_BIT];
        end
    end

endmodule

// File: rtl/pb_port_slice.sv
// Module: pb_port_slice
// Holds the state of one port and applies the decoded actions to it, gated
// by the port mode and the cooldown input. A clear (power clear, port
// reset or global reset) overrides every set that lands on the same edge.
module pb_port_slice
    import pb_cmd_pkg::*;
#(
    parameter int STAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_cmd_t         cmd,
    input  logic              glob_rst,
    input  logic [1:0]        mode,
    input  logic              cool_busy,
    input  logic              det_evt_set,
    input  logic              flt_evt_set,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_in,
    output logic              det_start,
    output logic              cls_start,
    output logic              pwr_en,
    output logic              det_en,
    output logic              cls_en,
    output logic              det_evt,
    output logic              flt_evt,
    output logic [STAT_W-1:0] status
);

    port_mode_e mode_e;
    logic is_off, is_manual, is_auto, wipe, set_ok;

    // Mode classification and action gating
    always_comb begin
        mode_e    = port_mode_e'(mode);
        is_off    = (mode_e == MODE_OFF);
        is_manual = (mode_e == MODE_MANUAL);
        is_auto   = (mode_e == MODE_SEMI) || (mode_e == MODE_AUTO);
        wipe      = cmd.port_rst || glob_rst || (cmd.pwr_clr && !is_off);
        set_ok    = cmd.pwr_set && !is_off && !cool_busy;
    end

    // In manual mode a restart bit becomes a start pulse
    assign det_start = cmd.det_go && is_manual;
    assign cls_start = cmd.cls_go && is_manual;

    // Port state: the clear cascade first, then the individual sets
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            pwr_en  <= 1'b0;
            det_en  <= 1'b0;
            cls_en  <= 1'b0;
            det_evt <= 1'b0;
            flt_evt <= 1'b0;
            status  <= '0;
        end else begin
            if (set_ok)                pwr_en  <= 1'b1;
            if (cmd.det_go && is_auto) det_en  <= 1'b1;
            if (cmd.cls_go && is_auto) cls_en  <= 1'b1;
            if (det_evt_set)           det_evt <= 1'b1;
            if (flt_evt_set)           flt_evt <= 1'b1;
            if (stat_wr)               status  <= stat_in;
        end
    end

    // R5: power enable rises only on an accepted set
    p_pwr_set_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> $past(cmd.pwr_set && !cool_busy && !is_off));

    // R6: a power clear leaves the whole port state empty
    p_clr_cascade_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd.pwr_clr && !is_off) |->
            (!pwr_en && !det_en && !cls_en && !det_evt && !flt_evt && status == '0));

    // R7: a port reset leaves the whole port state empty
    p_port_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd.port_rst) |->
            (!pwr_en && !det_en && !cls_en && !det_evt && !flt_evt && status == '0));

    // R4: enables are never set in manual or shutdown mode
    p_en_auto_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_en) |-> $past(is_auto));

endmodule

// File: rtl/pb_cmd_bank.sv
// Module: pb_cmd_bank (top)
// Command register bank for a multi-port power controller. It decodes the
// write-only command addresses, keeps the per-port state in one slice per
// port, and holds the global strap and undervoltage flags. Reads return
// zero. Assumes 2*NP <= DW and NP <= GLOB_BIT.
module pb_cmd_bank
    import pb_cmd_pkg::*;
#(
    parameter int NP     = 4,
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int STAT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    output logic [DW-1:0]          bus_rdata,
    input  logic [2*NP-1:0]        port_mode,
    input  logic [NP-1:0]          cool_busy,
    input  logic                   auto_strap,
    input  logic [NP-1:0]          det_evt_set,
    input  logic [NP-1:0]          flt_evt_set,
    input  logic [NP-1:0]          stat_wr,
    input  logic [NP*STAT_W-1:0]   stat_in,
    input  logic                   uvlo_set,
    output logic [NP-1:0]          det_start,
    output logic [NP-1:0]          cls_start,
    output logic [NP-1:0]          pwr_en,
    output logic [NP-1:0]          det_en,
    output logic [NP-1:0]          cls_en,
    output logic [NP-1:0]          det_evt,
    output logic [NP-1:0]          flt_evt,
    output logic [NP*STAT_W-1:0]   port_status,
    output logic                   auto_mode,
    output logic                   uvlo_flag
);

    localparam int GLOB_BIT = 4;

    port_cmd_t [NP-1:0] cmd_q;
    logic glob_q;

    pb_cmd_decode #(
        .NP(NP), .AW(AW), .DW(DW), .GLOB_BIT(GLOB_BIT)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .cmd_q     (cmd_q),
        .glob_q    (glob_q)
    );

    for (genvar i = 0; i < NP; i++) begin : g_port
        pb_port_slice #(.STAT_W(STAT_W)) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd         (cmd_q[i]),
            .glob_rst    (glob_q),
            .mode        (port_mode[2*i +: 2]),
            .cool_busy   (cool_busy[i]),
            .det_evt_set (det_evt_set[i]),
            .flt_evt_set (flt_evt_set[i]),
            .stat_wr     (stat_wr[i]),
            .stat_in     (stat_in[STAT_W*i +: STAT_W]),
            .det_start   (det_start[i]),
            .cls_start   (cls_start[i]),
            .pwr_en      (pwr_en[i]),
            .det_en      (det_en[i]),
            .cls_en      (cls_en[i]),
            .det_evt     (det_evt[i]),
            .flt_evt     (flt_evt[i]),
            .status      (port_status[STAT_W*i +: STAT_W])
        );

        // R9: a start pulse is never held for two cycles by one write
        p_one_cycle_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (det_start[i] || cls_start[i]) |=>
                (!(det_start[i] || cls_start[i]) || $past(bus_wr)));
    end

    // Global flags: strap latch and undervoltage flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_mode <= auto_strap;
            uvlo_flag <= 1'b1;
        end else if (glob_q) begin
            auto_mode <= auto_strap;
            uvlo_flag <= 1'b0;
        end else if (uvlo_set) begin
            uvlo_flag <= 1'b1;
        end
    end

    // Read path: every register here is write-only and reads as zero
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= '0;
    end

    // R8: a global reset reloads the strap and leaves the flag clear
    p_global_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(glob_q) |-> (!uvlo_flag && auto_mode == $past(auto_strap) && pwr_en == '0));

endmodule

// File: tb/pb_cmd_bank_tb.sv
// Bench for pb_cmd_bank: directed corner cases, then seeded random writes,
// all checked against a reference model kept in the bench.
`timescale 1ns/1ps
module pb_cmd_bank_tb;

    localparam int NP = 4;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2*NP-1:0] port_mode = '0;
    logic [NP-1:0] cool_busy = '0, det_evt_set = '0, flt_evt_set = '0, stat_wr = '0;
    logic [NP*SW-1:0] stat_in = '0;
    logic auto_strap = 1'b1, uvlo_set = 1'b0;
    logic [NP-1:0] det_start, cls_start, pwr_en, det_en, cls_en, det_evt, flt_evt;
    logic [NP*SW-1:0] port_status;
    logic auto_mode, uvlo_flag;

    // Reference model
    logic [NP-1:0] e_pwr, e_den, e_cen, e_dev, e_fev;
    logic [NP*SW-1:0] e_st;
    logic e_auto, e_uvlo;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pb_cmd_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .port_mode(port_mode), .cool_busy(cool_busy), .auto_strap(auto_strap),
        .det_evt_set(det_evt_set), .flt_evt_set(flt_evt_set), .stat_wr(stat_wr),
        .stat_in(stat_in), .uvlo_set(uvlo_set), .det_start(det_start),
        .cls_start(cls_start), .pwr_en(pwr_en), .det_en(det_en), .cls_en(cls_en),
        .det_evt(det_evt), .flt_evt(flt_evt), .port_status(port_status),
        .auto_mode(auto_mode), .uvlo_flag(uvlo_flag)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Clear one port in the model
    task automatic m_wipe(input int i);
        e_pwr[i] = 0; e_den[i] = 0; e_cen[i] = 0; e_dev[i] = 0; e_fev[i] = 0;
        e_st[SW*i +: SW] = '0;
    endtask

    function automatic logic [NP-1:0] exp_start(input logic [7:0] a, input logic [7:0] d,
                                                input int base);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++)
            r[i] = (a == 8'h18) && d[base+i] && (port_mode[2*i +: 2] == 2'b01);
        return r;
    endfunction

    task automatic chk_state(input string req);
        chk(req, "pwr_en", 32'(pwr_en), 32'(e_pwr));
        chk(req, "det_en", 32'(det_en), 32'(e_den));
        chk(req, "cls_en", 32'(cls_en), 32'(e_cen));
        chk(req, "det_evt", 32'(det_evt), 32'(e_dev));
        chk(req, "flt_evt", 32'(flt_evt), 32'(e_fev));
        chk(req, "status", 32'(port_status), 32'(e_st));
        chk(req, "auto_mode", 32'(auto_mode), 32'(e_auto));
        chk(req, "uvlo_flag", 32'(uvlo_flag), 32'(e_uvlo));
    endtask

    // Bus write at a negedge; pulses checked one cycle later, state one more
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
        logic [NP-1:0] xd, xc;
        xd = exp_start(a, d, 0);
        xc = exp_start(a, d, NP);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R3", "det_start", 32'(det_start), 32'(xd));
        chk("R3", "cls_start", 32'(cls_start), 32'(xc));
        for (int i = 0; i < NP; i++) begin
            logic [1:0] m;
            m = port_mode[2*i +: 2];
            if (a == 8'h18 && m[1]) begin
                if (d[i]) e_den[i] = 1;
                if (d[NP+i]) e_cen[i] = 1;
            end else if (a == 8'h19 && m != 2'b00) begin
                if (d[NP+i]) m_wipe(i);
                else if (d[i] && !cool_busy[i]) e_pwr[i] = 1;
            end else if (a == 8'h1A && (d[i] || d[4])) begin
                m_wipe(i);
            end
        end
        if (a == 8'h1A && d[4]) begin
            e_auto = auto_strap; e_uvlo = 0;
        end
        @(negedge clk);
        chk("R9", "pulse gone", 32'({det_start, cls_start}), 32'h0);
        chk_state(req);
    endtask

    // Drive event/status/uvlo inputs for one edge
    task automatic ev(input logic [NP-1:0] dv, input logic [NP-1:0] fv,
                      input logic [NP-1:0] sw, input logic [NP*SW-1:0] sv, input logic uv);
        det_evt_set = dv; flt_evt_set = fv; stat_wr = sw; stat_in = sv; uvlo_set = uv;
        @(negedge clk);
        det_evt_set = '0; flt_evt_set = '0; stat_wr = '0; uvlo_set = 1'b0;
        e_dev |= dv; e_fev |= fv;
        for (int i = 0; i < NP; i++) if (sw[i]) e_st[SW*i +: SW] = sv[SW*i +: SW];
        if (uv) e_uvlo = 1;
        chk_state("R10");
    endtask

    // Watchdog
    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        e_pwr = 0; e_den = 0; e_cen = 0; e_dev = 0; e_fev = 0; e_st = 0;
        e_auto = 1; e_uvlo = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R8 reset");

        // R1: reads return zero
        bus_rd = 1'b1; bus_addr = 8'h19;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R1", "rdata", 32'(bus_rdata), 32'h0);

        // R3: manual-mode start pulses
        port_mode = 8'b01_01_01_01;
        wr(8'h18, 8'hA5, "R3");
        // R4: auto/semi sets enables, shutdown ignored
        port_mode = 8'b11_10_00_01;
        wr(8'h18, 8'hFF, "R4");
        // R5: set refused by cooldown and shutdown
        cool_busy = 4'b0100;
        wr(8'h19, 8'h0F, "R5");
        cool_busy = 4'b0000;
        wr(8'h19, 8'h0F, "R5");
        // R10: events and status
        ev(4'hF, 4'hA, 4'hF, 12'hABC, 1'b0);
        // R6: clear wins over set on the same port; shutdown port untouched
        port_mode = 8'b11_11_11_00;
        wr(8'h19, 8'h33, "R6");
        // R2: zero data and an unused address change nothing
        wr(8'h19, 8'h00, "R2");
        wr(8'h1B, 8'hFF, "R2");
        // R7: port reset works in shutdown
        ev(4'hF, 4'hF, 4'hF, 12'h777, 1'b0);
        wr(8'h1A, 8'h01, "R7");
        wr(8'h1A, 8'h20, "R8 bit5");

        // R10: clear lands on the same edge as an event set
        port_mode = 8'b11_11_11_11;
        bus_addr = 8'h19; bus_wdata = 8'h20; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; det_evt_set = 4'b0010; stat_wr = 4'b0010; stat_in = 12'hFFF;
        @(negedge clk);
        det_evt_set = '0; stat_wr = '0;
        m_wipe(1);
        chk_state("R10 clear wins");

        // R8: global reset with a new strap value
        wr(8'h19, 8'h0F, "R5");
        auto_strap = 1'b0;
        wr(8'h1A, 8'h10, "R8");
        ev(4'h0, 4'h0, 4'h0, 12'h0, 1'b1);

        // Random phase
        for (int n = 0; n < 400; n++) begin
            int k;
            port_mode = 8'($urandom);
            cool_busy = 4'($urandom);
            k = int'($urandom_range(0, 9));
            if (k < 7) begin
                logic [7:0] a, d;
                a = 8'h18 + 8'($urandom_range(0, 3));
                d = 8'($urandom);
                if (a == 8'h1A && $urandom_range(0, 3) != 0) d[4] = 1'b0;
                auto_strap = 1'($urandom);
                wr(a, d, "R2");
            end else begin
                ev(4'($urandom), 4'($urandom), 4'($urandom), 12'($urandom), 1'($urandom));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule